// File: doc/BRIEF.md
# Dual-Lane Ping-Pong Buffer Manager

The block streams 32-bit words out of two block RAMs, one for polarization codes and one for decoy codes, to a consumer inside the fabric. Each RAM is treated as two equal halves. One address pointer serves both lanes, so the two lanes always read the same address and change halves in the same cycle. Each time the pointer leaves a half, the block raises a sticky interrupt flag and records which half was released. The host then refills that half through a plain write port while the consumer drains the other half.

The consumer pulls a word by asserting `adv_i`. The word comes out one cycle later with `valid_o`. The pointer wraps from the last address back to zero, so the stream never stops while `enable_i` is high. If the pointer finishes a half while the previous interrupt has not been cleared, a sticky error flag is set. This means the host fell behind. Dropping `enable_i` returns the pointer to zero and clears every flag.

Top module: `pp_buffer_mgr`

## Requirements
- R1: After `rst_ni` is released, `valid_o`, `irq_o`, `half_o`, `err_o`, `pol_data_o` and `dec_data_o` are all zero.
- R2: When `enable_i` and `adv_i` are both high in a cycle, the words at the current pointer appear on `pol_data_o` and `dec_data_o` at the next clock edge, and `valid_o` is high for exactly that one cycle.
- R3: Successive reads visit addresses 0, 1, …, DEPTH-1 and then wrap to 0. Both lanes are always read at the same address.
- R4: A read at address DEPTH/2-1 sets `irq_o` at the next edge, with `half_o` = 0 (lower half released).
- R5: A read at address DEPTH-1 sets `irq_o` at the next edge, with `half_o` = 1 (upper half released).
- R6: `irq_o` stays set until `irq_clr_i` is high for a cycle, and it drops at the next edge. When a clear arrives in the same cycle as a half-boundary read, the new event wins and `irq_o` stays set.
- R7: A half-boundary read while `irq_o` is set and `irq_clr_i` is low sets `err_o`. `err_o` then stays set while enabled.
- R8: When `cpu_we_i` is high, `cpu_wdata_i` is written at `cpu_addr_i` into the lane chosen by `cpu_lane_i` (0 = polarization, 1 = decoy). The other lane is left unchanged. A read and a write to the same address in one cycle returns the old word.
- R9: While `enable_i` is low, `adv_i` is ignored. The next edge returns the pointer to 0 and clears `valid_o`, `irq_o`, `half_o` and `err_o`. The data outputs hold their last values.
- R10: In a cycle with `adv_i` low, the pointer holds and `valid_o` is low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run control; low resets the pointer and the flags |
| adv_i | input | 1 | Consumer request for the next word |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| cpu_we_i | input | 1 | Host write strobe |
| cpu_lane_i | input | 1 | Host lane select: 0 polarization, 1 decoy |
| cpu_addr_i | input | $clog2(DEPTH) | Host write address |
| cpu_wdata_i | input | DW | Host write data |
| pol_data_o | output | DW | Polarization lane word |
| dec_data_o | output | DW | Decoy lane word |
| valid_o | output | 1 | Word strobe, one cycle after a request |
| irq_o | output | 1 | Sticky half-released flag |
| half_o | output | 1 | Half just released: 0 lower, 1 upper |
| err_o | output | 1 | Sticky flag: host did not service a half in time |

## Verification
The assertions keep their own count of requests, started from reset and from each enable. They therefore assume the pointer moves only on enabled requests and that the host clears the flag with single pulses. The assertions do not check data integrity. That depends on the host never writing the word being read in the same cycle. During streaming, the stimulus writes only to the address half a buffer ahead of the pointer. It fills the whole buffer only while the block is disabled, so every read in the bench has a defined expected word. Request gaps, a clear held high across boundary reads, and missed clears are run as separate phases.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned NUM_LANES = 2;
  typedef enum logic {
    LANE_POL = 1'b0,
    LANE_DEC = 1'b1
  } lane_e;
endpackage

// File: rtl/pp_ptr.sv
module pp_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          evt_o,
  output logic          evt_upper_o
);
  localparam logic [AW-1:0] LAST_LO = AW'(DEPTH/2 - 1);
  localparam logic [AW-1:0] LAST_HI = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic          step;

  assign step        = en_i & adv_i;
  assign addr_o      = ptr_q;
  assign evt_upper_o = step & (ptr_q == LAST_HI);
  assign evt_o       = step & ((ptr_q == LAST_LO) | (ptr_q == LAST_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (!en_i)      ptr_q <= '0;
    else if (adv_i)      ptr_q <= (ptr_q == LAST_HI) ? '0 : ptr_q + AW'(1);
  end
endmodule

// File: rtl/pp_ram.sv
module pp_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-first: same-cycle write is seen on the next read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pp_irq.sv
module pp_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic evt_i,
  input  logic evt_upper_i,
  input  logic clr_i,
  output logic irq_o,
  output logic half_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      half_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (!en_i) begin
      irq_o  <= 1'b0;
      half_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (evt_i) begin
      // a new release beats a same-cycle clear
      if (irq_o && !clr_i) err_o <= 1'b1;
      irq_o  <= 1'b1;
      half_o <= evt_upper_i;
    end else if (clr_i) begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_buffer_mgr.sv
module pp_buffer_mgr
  import pp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          adv_i,
  input  logic          irq_clr_i,
  input  logic          cpu_we_i,
  input  logic          cpu_lane_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] pol_data_o,
  output logic [DW-1:0] dec_data_o,
  output logic          valid_o,
  output logic          irq_o,
  output logic          half_o,
  output logic          err_o
);
  logic [AW-1:0] rd_addr;
  logic          evt, evt_upper, rd_en;
  logic [DW-1:0] lane_data [NUM_LANES];

  assign rd_en = enable_i & adv_i;

  pp_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enable_i),
    .adv_i       (adv_i),
    .addr_o      (rd_addr),
    .evt_o       (evt),
    .evt_upper_o (evt_upper)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = cpu_we_i & (cpu_lane_i == 1'(g));
    pp_ram #(.DW(DW), .DEPTH(DEPTH)) i_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (lane_we),
      .waddr_i (cpu_addr_i),
      .wdata_i (cpu_wdata_i),
      .re_i    (rd_en),
      .raddr_i (rd_addr),
      .rdata_o (lane_data[g])
    );
  end

  assign pol_data_o = lane_data[int'(LANE_POL)];
  assign dec_data_o = lane_data[int'(LANE_DEC)];

  pp_irq i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enable_i),
    .evt_i       (evt),
    .evt_upper_i (evt_upper),
    .clr_i       (irq_clr_i),
    .irq_o       (irq_o),
    .half_o      (half_o),
    .err_o       (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= rd_en;
  end
endmodule

// File: rtl/pp_buffer_mgr_chk.sv
module pp_buffer_mgr_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic adv_i,
  input logic irq_clr_i,
  input logic valid_o,
  input logic irq_o,
  input logic half_o,
  input logic err_o
);
  logic [AW-1:0] cnt_q;
  logic          lo_end, hi_end, bnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!enable_i)         cnt_q <= '0;
    else if (adv_i)             cnt_q <= (int'(cnt_q) == DEPTH - 1) ? '0 : cnt_q + AW'(1);
  end

  assign lo_end = enable_i && adv_i && (int'(cnt_q) == DEPTH/2 - 1);
  assign hi_end = enable_i && adv_i && (int'(cnt_q) == DEPTH - 1);
  assign bnd    = lo_end || hi_end;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && adv_i) |=> valid_o); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && adv_i) |=> !valid_o); // R10
  AST_LOWER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_end |=> (irq_o && !half_o)); // R4
  AST_UPPER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_end |=> (irq_o && half_o)); // R5
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && irq_o && !irq_clr_i) |=> irq_o); // R6
  AST_ERR_ON_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && irq_o && !irq_clr_i) |=> err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && err_o) |=> err_o); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!irq_o && !err_o && !valid_o && !half_o)); // R9
endmodule

bind pp_buffer_mgr pp_buffer_mgr_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_pp_buffer_mgr.sv
`timescale 1ns/1ps
module test_pp_buffer_mgr;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, adv = 1'b0, clr = 1'b0, we = 1'b0, lane = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wd = '0;
  logic [31:0]   pol_d, dec_d;
  logic          vld, irq, half, err;

  always #4 clk = ~clk;

  pp_buffer_mgr #(.DW(32), .DEPTH(DEPTH)) i_pp_buffer_mgr (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .adv_i(adv), .irq_clr_i(clr),
    .cpu_we_i(we), .cpu_lane_i(lane), .cpu_addr_i(addr), .cpu_wdata_i(wd),
    .pol_data_o(pol_d), .dec_data_o(dec_d), .valid_o(vld), .irq_o(irq),
    .half_o(half), .err_o(err)
  );

  // behavioural reference
  logic [31:0] m_pol [DEPTH];
  logic [31:0] m_dec [DEPTH];
  int          m_ptr;
  logic        m_vld, m_irq, m_half, m_err;
  logic [31:0] m_dp, m_dd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_vld = 0; m_irq = 0; m_half = 0; m_err = 0; m_dp = 0; m_dd = 0;
    end else begin
      bit ev, up;
      ev = 0; up = 0;
      if (!en) begin
        m_ptr = 0; m_vld = 0; m_irq = 0; m_half = 0; m_err = 0;
      end else begin
        m_vld = adv;
        if (adv) begin
          m_dp = m_pol[m_ptr];
          m_dd = m_dec[m_ptr];
          ev = (m_ptr == HALF - 1) || (m_ptr == DEPTH - 1);
          up = (m_ptr == DEPTH - 1);
          m_ptr = (m_ptr + 1) % DEPTH;
        end
        if (ev) begin
          if (m_irq && !clr) m_err = 1;
          m_irq = 1;
          m_half = up;
        end else if (clr) m_irq = 0;
      end
      if (we) begin
        if (lane) m_dec[addr] = wd;
        else      m_pol[addr] = wd;
      end
    end
  end

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input string fld, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, fld, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("valid", 32'(vld), 32'(m_vld));
    chk("irq", 32'(irq), 32'(m_irq));
    chk("half", 32'(half), 32'(m_half));
    chk("err", 32'(err), 32'(m_err));
    chk("pol_data", pol_d, m_dp);
    chk("dec_data", dec_d, m_dd);
  endtask

  task automatic cyc(input logic e, input logic a, input logic c, input logic w,
                     input logic l, input int ad, input logic [31:0] d);
    en = e; adv = a; clr = c; we = w; lane = l; addr = AW'(ad); wd = d;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  // streaming with background refill half a buffer ahead of the pointer
  task automatic stream(input int n, input int gap, input int clr_mode, input logic [7:0] tag);
    for (int c = 0; c < n; c++) begin
      logic a, cl;
      a  = (gap == 0) ? 1'b1 : (c % gap == 0);
      cl = (clr_mode == 0) ? m_irq : (clr_mode == 1);
      cyc(1'b1, a, cl, 1'b1, c[0], (m_ptr + HALF) % DEPTH,
          {tag, 7'(c), c[0], 16'((m_ptr + HALF) % DEPTH)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    @(negedge clk);
    compare_all();

    // R8: fill both lanes while disabled, adv ignored (R9)
    cur_req = "R8";
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, i, 32'hA000_0000 + 32'(i));
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, i, 32'hD000_0000 + 32'(i));
    end
    // overwrite polarization word 5 only; decoy must be untouched
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5, 32'h5555_AAAA);

    cur_req = "R2";  stream(4, 0, 0, 8'h11);
    cur_req = "R4";  stream(5, 0, 0, 8'h12);
    cur_req = "R5";  stream(8, 0, 0, 8'h13);
    cur_req = "R3";  stream(30, 0, 0, 8'h14);
    cur_req = "R10"; stream(30, 3, 0, 8'h15);
    cur_req = "R6";  stream(20, 0, 1, 8'h16);
    cur_req = "R6";  stream(6, 0, 2, 8'h17);
    cur_req = "R7";  stream(20, 0, 2, 8'h18);
    cur_req = "R9";
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 32'h0);
    stream(6, 0, 0, 8'h19);
    // same-address read and write: old word is returned (R8)
    cur_req = "R8";
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, m_ptr, 32'hBEEF_0001);
    stream(20, 0, 0, 8'h1A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule